// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block lets a processor reach the management registers of external PHY devices over a two-wire MDIO bus using Clause 45 indirect addressing. Software sees four 32-bit registers behind a simple single-cycle write port with a combinational read-back. Register writes launch the serial frames directly. Storing a register number sends an address frame to the selected port and device. Storing a 16-bit value sends a write frame. Setting a read request in the command register sends a read frame, and the returned value then appears in the data register.

The block makes MDC from the system clock with a programmable half-period count. It drives MDIO through separate output and output-enable pins and samples the returned line on a separate input. There are two busy flags, one per access stage. The address-stage busy flag sits in the configuration/status register, and the data-stage busy flag sits in the data register. A read-error flag reports a PHY that did not answer the turnaround.

Software normally programs the divider first. It then writes the command register with the port and device, writes the register number and waits for the address busy flag to clear. After that it either writes the data register, or writes the command register with the read request, and waits for the data busy flag to clear.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset, the configuration/status register (offset 0) reads the default divider in bits 15:8 and 0 elsewhere. The command (offset 1), register-number (offset 2) and data (offset 3) registers read 0. MDC and the MDIO output enable are low.
- R2: A write to offset 2 while idle stores bits 15:0 and sends an address frame. The frame is 32 ones, then 00, then opcode 00, then the 5-bit port {00, command bits 7:5}, then the 5-bit device (command bits 4:0), then turnaround 10, then the 16 bits, most significant bit first.
- R3: A write to offset 3 while idle stores bits 15:0 and sends the same frame layout with opcode 01, carrying that value.
- R4: A write to offset 1 with bit 15 set while idle sends a frame with opcode 11, addressed by bits 7:0 of that write. The master stops driving MDIO for the last 18 bit times (both turnaround bits and 16 data bits). After the frame, data bits 15:0 hold the 16 bits sampled, most significant bit first.
- R5: Bit 0 of offset 0 is 1 exactly while an address frame runs. Bit 31 of offset 3 is 1 exactly while a write or read frame runs. The two flags are never 1 together, and the output enable is low whenever both are 0.
- R6: Bit 1 of offset 0 is cleared when a read frame starts. At the end of that frame it is set if the second turnaround bit was sampled high.
- R7: An MDC half period lasts max(D,1) system clock cycles, where D is bits 15:8 of offset 0. A frame takes 128 half periods. MDC is low when no frame runs.
- R8: The MDIO output changes only on cycles where MDC falls, or when a frame starts while MDC is low. It never changes while MDC is high, and MDIO is sampled on the rising MDC edge.
- R9: A write to offset 2, a write to offset 3, or a write to offset 1 with bit 15 set is ignored while any frame runs. No register changes, no frame is queued and the busy flags keep their values.
- R10: A write to offset 1 with bit 15 clear only stores bits 7:0 and starts no frame. Bit 15 always reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_addr | input | 2 | Register offset for write and read-back |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read-back of the register at reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line value seen by the master |

## Verification
The assertions assume that a write strobe lasts one clock and carries a defined offset. They also assume the external PHY drives the line only while the master's enable is low and changes it only after MDC falls. The bench writes registers through one task that raises the strobe for exactly one cycle. Its PHY model changes the line only on the falling MDC edge and only in the read data phase. The divider is reprogrammed only while no frame runs, so the half-period count seen by the frame timing checks stays constant within each frame.

// File: rtl/mdio_pkg.sv
// Package: shared constants and types for the Clause 45 MDIO master.
// Assumes a 32-bit register port with four word offsets.
package mdio_pkg;

    // Frame kind; the encoding equals the two opcode bits sent on the wire.
    typedef enum logic [1:0] {
        FK_ADDR  = 2'b00,
        FK_WRITE = 2'b01,
        FK_READ  = 2'b11
    } frame_kind_e;

    localparam int REG_W = 32;

    // Register offsets
    localparam logic [1:0] RA_CFG     = 2'd0;
    localparam logic [1:0] RA_CMD     = 2'd1;
    localparam logic [1:0] RA_REGADDR = 2'd2;
    localparam logic [1:0] RA_DATA    = 2'd3;

    // Field positions
    localparam int CFG_BUSY_BIT  = 0;
    localparam int CFG_RDERR_BIT = 1;
    localparam int CFG_DIV_LSB   = 8;
    localparam int CMD_READ_BIT  = 15;
    localparam int DATA_BUSY_BIT = 31;

endpackage

// File: rtl/mdio_clk_gen.sv
// Module: mdio_clk_gen
// Makes MDC from the system clock while a frame runs. Each half period lasts
// max(half_cnt,1) cycles. Gives one-cycle strobes on the edges where MDC is about to
// rise or fall. Assumes half_cnt is stable while run is high. MDC idles low.
module mdio_clk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_cnt,
    output logic             mdc,
    output logic             rise_evt,
    output logic             fall_evt
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;
    logic             tick;

    // Half-period length with a floor of one cycle, and the toggle condition
    always_comb begin
        limit    = (half_cnt == '0) ? DIV_W'(1) : half_cnt;
        tick     = run && (cnt >= limit - 1'b1);
        rise_evt = tick && !mdc;
        fall_evt = tick && mdc;
    end

    // Half-period counter and MDC toggle flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= !mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mdio_frame_engine.sv
// Module: mdio_frame_engine
// Serialises one Clause 45 frame: preamble, start, opcode, port, device,
// turnaround and 16 payload bits. The line is updated on fall strobes and sampled
// on rise strobes. On reads it releases the line at the first turnaround bit,
// checks the second turnaround bit and shifts in the data bits. Assumes start is
// raised only while idle.
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int PRE_BITS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  frame_kind_e kind,
    input  logic [4:0]  prt,
    input  logic [4:0]  dev,
    input  logic [15:0] payload,
    input  logic        rise_evt,
    input  logic        fall_evt,
    input  logic        mdio_i,
    output logic        active,
    output frame_kind_e kind_q,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        finish,
    output logic [15:0] rd_data,
    output logic        ta_err
);

    localparam int FRAME_LEN = PRE_BITS + 32;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] PRE_TA   = IDX_W'(PRE_BITS + 13);
    localparam logic [IDX_W-1:0] TA2_POS  = IDX_W'(PRE_BITS + 15);
    localparam logic [IDX_W-1:0] DATA_POS = IDX_W'(PRE_BITS + 16);

    logic [FRAME_LEN-1:0] frame_vec;
    logic [FRAME_LEN-1:0] shreg;
    logic [IDX_W-1:0]     idx;

    // Assemble the full frame from the launch fields
    always_comb begin
        frame_vec = {{PRE_BITS{1'b1}}, 2'b00, kind, prt, dev, 2'b10, payload};
        finish    = active && fall_evt && (idx == LAST_POS);
    end

    // Frame state: launch, bit advance on MDC fall, line release and end of frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            kind_q  <= FK_ADDR;
            shreg   <= '0;
            idx     <= '0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
        end else if (start && !active) begin
            active  <= 1'b1;
            kind_q  <= kind;
            shreg   <= frame_vec;
            idx     <= '0;
            mdio_o  <= frame_vec[FRAME_LEN-1];
            mdio_oe <= 1'b1;
        end else if (active && fall_evt) begin
            if (idx == LAST_POS) begin
                active  <= 1'b0;
                mdio_oe <= 1'b0;
                mdio_o  <= 1'b0;
            end else begin
                idx    <= idx + 1'b1;
                shreg  <= {shreg[FRAME_LEN-2:0], 1'b0};
                mdio_o <= shreg[FRAME_LEN-2];
                if (kind_q == FK_READ && idx == PRE_TA) begin
                    mdio_oe <= 1'b0;
                end
            end
        end
    end

    // Read capture: turnaround check and data shift on MDC rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            ta_err  <= 1'b0;
        end else if (start && !active) begin
            rd_data <= '0;
            ta_err  <= 1'b0;
        end else if (active && rise_evt && kind_q == FK_READ) begin
            if (idx == TA2_POS) begin
                ta_err <= mdio_i;
            end
            if (idx >= DATA_POS) begin
                rd_data <= {rd_data[14:0], mdio_i};
            end
        end
    end

endmodule

// File: rtl/mdio_c45_master.sv
// Module: mdio_c45_master (top)
// Register front end of the Clause 45 MDIO master. It holds the divider, the
// combined port/device address, the register number and the data word. It turns
// frame-starting writes into launches and drops them while a frame runs.
// Assumes one-cycle write strobes. Read-back is combinational and has no side effects.
module mdio_c45_master
    import mdio_pkg::*;
#(
    parameter int             DIV_W    = 8,
    parameter logic [DIV_W-1:0] DIV_RST = DIV_W'(50),
    parameter int             PRE_BITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);

    logic [DIV_W-1:0] div_q;
    logic [7:0]       phy_addr_q;
    logic [15:0]      regaddr_q;
    logic [15:0]      data_q;
    logic             rd_err_q;

    logic             eng_active;
    frame_kind_e      eng_kind;
    logic             eng_finish;
    logic [15:0]      eng_rd_data;
    logic             eng_ta_err;
    logic             rise_evt;
    logic             fall_evt;

    logic             wr_cfg, wr_cmd, wr_ra, wr_dat;
    logic             go_addr, go_write, go_read, go_any;
    frame_kind_e      go_kind;
    logic [7:0]       go_addr8;
    logic             addr_busy, data_busy;

    // Decode writes and decide whether a frame launches this cycle
    always_comb begin
        wr_cfg   = reg_wr && (reg_addr == RA_CFG);
        wr_cmd   = reg_wr && (reg_addr == RA_CMD);
        wr_ra    = reg_wr && (reg_addr == RA_REGADDR);
        wr_dat   = reg_wr && (reg_addr == RA_DATA);
        go_addr  = wr_ra && !eng_active;
        go_write = wr_dat && !eng_active;
        go_read  = wr_cmd && reg_wdata[CMD_READ_BIT] && !eng_active;
        go_any   = go_addr || go_write || go_read;
        go_kind  = go_addr ? FK_ADDR : (go_write ? FK_WRITE : FK_READ);
        go_addr8 = go_read ? reg_wdata[7:0] : phy_addr_q;
        addr_busy = eng_active && (eng_kind == FK_ADDR);
        data_busy = eng_active && (eng_kind != FK_ADDR);
    end

    // Software-visible register state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q      <= DIV_RST;
            phy_addr_q <= '0;
            regaddr_q  <= '0;
            data_q     <= '0;
            rd_err_q   <= 1'b0;
        end else begin
            if (wr_cfg) begin
                div_q <= reg_wdata[CFG_DIV_LSB +: DIV_W];
            end
            if (wr_cmd && !(reg_wdata[CMD_READ_BIT] && eng_active)) begin
                phy_addr_q <= reg_wdata[7:0];
            end
            if (go_addr) begin
                regaddr_q <= reg_wdata[15:0];
            end
            if (go_write) begin
                data_q <= reg_wdata[15:0];
            end
            if (go_read) begin
                rd_err_q <= 1'b0;
            end
            if (eng_finish && eng_kind == FK_READ) begin
                data_q   <= eng_rd_data;
                rd_err_q <= eng_ta_err;
            end
        end
    end

    // Combinational read-back multiplexer
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_CFG: begin
                reg_rdata[CFG_DIV_LSB +: DIV_W] = div_q;
                reg_rdata[CFG_RDERR_BIT]        = rd_err_q;
                reg_rdata[CFG_BUSY_BIT]         = addr_busy;
            end
            RA_CMD:     reg_rdata[7:0]  = phy_addr_q;
            RA_REGADDR: reg_rdata[15:0] = regaddr_q;
            default: begin
                reg_rdata[15:0]          = data_q;
                reg_rdata[DATA_BUSY_BIT] = data_busy;
            end
        endcase
    end

    mdio_clk_gen #(
        .DIV_W    (DIV_W)
    ) i_clk_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (eng_active),
        .half_cnt (div_q),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    mdio_frame_engine #(
        .PRE_BITS (PRE_BITS)
    ) i_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (go_any),
        .kind     (go_kind),
        .prt      ({2'b00, go_addr8[7:5]}),
        .dev      (go_addr8[4:0]),
        .payload  (reg_wdata[15:0]),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .mdio_i   (mdio_i),
        .active   (eng_active),
        .kind_q   (eng_kind),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .finish   (eng_finish),
        .rd_data  (eng_rd_data),
        .ta_err   (eng_ta_err)
    );

endmodule

// File: rtl/mdio_c45_checker.sv
// Module: mdio_c45_checker
// Concurrent checks on the MDIO master, attached to the top by bind.
// Assumes one-cycle write strobes and a PHY that drives only while mdio_oe is low.
module mdio_c45_checker
    import mdio_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        addr_busy,
    input logic        data_busy,
    input logic [15:0] regaddr_q
);

    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_busy || data_busy) |-> !mdc); // R7

    AST_OUT_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> $stable(mdio_o)); // R8

    AST_SINGLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_busy && data_busy)); // R5

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_busy || data_busy) |-> !mdio_oe); // R5

    AST_REGADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr_busy || data_busy) && reg_wr && reg_addr == RA_REGADDR)
        |=> $stable(regaddr_q)); // R9

    AST_NO_DATA_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_busy && reg_wr && reg_addr == RA_DATA) |=> !data_busy); // R9

endmodule

bind mdio_c45_master mdio_c45_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .addr_busy (addr_busy),
    .data_busy (data_busy),
    .regaddr_q (regaddr_q)
);

// File: tb/test_mdio_c45_master.sv
// Bench: vector table of frames walked by one loop, then directed tests
// for reset, ignored writes, the divider floor and line timing.
module test_mdio_c45_master;
    import mdio_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_line;

    logic        phy_oe = 1'b0;
    logic        phy_bit = 1'b1;
    logic        phy_is_read = 1'b0;
    logic        phy_err = 1'b0;
    logic [15:0] phy_data = '0;
    int          rx_cnt = 0;
    int          oe_low_cnt = 0;
    int          frame_base = 0;
    logic [63:0] rx_bits = '0;
    logic        rise_val = 1'b0;
    int          r8_viol = 0;

    int n_checks = 0;
    int n_fail = 0;

    // kind[1:0] | addr8 | value16 | phy data16 | error inject
    localparam logic [42:0] VEC [7] = '{
        {2'b00, 8'hA5, 16'h1234, 16'h0000, 1'b0},
        {2'b01, 8'hA5, 16'hBEEF, 16'h0000, 1'b0},
        {2'b11, 8'hA5, 16'h0000, 16'hC3A5, 1'b0},
        {2'b00, 8'h3F, 16'h8001, 16'h0000, 1'b0},
        {2'b11, 8'h3F, 16'h0000, 16'h0F0F, 1'b1},
        {2'b11, 8'hE0, 16'h0000, 16'h5A5A, 1'b0},
        {2'b01, 8'h1E, 16'h4321, 16'h0000, 1'b0}
    };

    assign mdio_line = mdio_oe ? mdio_o : (phy_oe ? phy_bit : 1'b1);

    mdio_c45_master i_mdio_c45_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_line)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // PHY model: sample the line on MDC rise
    always @(posedge mdc) begin
        rx_bits  = {rx_bits[62:0], mdio_line};
        if (!mdio_oe) oe_low_cnt = oe_low_cnt + 1;
        rx_cnt   = rx_cnt + 1;
        rise_val = mdio_o;
    end

    // PHY model: drive turnaround and read data after MDC falls
    always @(negedge mdc) begin
        automatic int k = rx_cnt - frame_base;
        phy_oe  = 1'b0;
        phy_bit = 1'b1;
        if (phy_is_read && !phy_err) begin
            if (k == 47) begin
                phy_oe = 1'b1; phy_bit = 1'b0;
            end else if (k >= 48 && k <= 63) begin
                phy_oe = 1'b1; phy_bit = phy_data[63-k];
            end
        end
    end

    // R8 monitor: output must hold while MDC is high
    always @(negedge clk) begin
        if (mdc === 1'b1 && mdio_o !== rise_val) r8_viol = r8_viol + 1;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_idle(output int cycles, output logic sa, output logic sd);
        logic [31:0] c, dv;
        cycles = 0;
        rd(RA_CFG, c); rd(RA_DATA, dv);
        sa = c[CFG_BUSY_BIT]; sd = dv[DATA_BUSY_BIT];
        while ((c[CFG_BUSY_BIT] || dv[DATA_BUSY_BIT]) && cycles < 100000) begin
            cycles++;
            @(negedge clk);
            rd(RA_CFG, c); rd(RA_DATA, dv);
        end
    endtask

    task automatic run_frame(input logic [1:0] a, input logic [31:0] d,
                             output int cycles, output logic sa, output logic sd);
        frame_base = rx_cnt;
        wr(a, d);
        wait_idle(cycles, sa, sd);
    endtask

    function automatic logic [63:0] exp_frame(input logic [1:0] k, input logic [7:0] a,
                                              input logic [15:0] v, input logic [15:0] pd,
                                              input logic e);
        logic [1:0]  ta;
        logic [15:0] pl;
        if (k == 2'b11) begin
            ta = {1'b1, e}; pl = e ? 16'hFFFF : pd;
        end else begin
            ta = 2'b10; pl = v;
        end
        return {32'hFFFF_FFFF, 2'b00, k, 2'b00, a[7:5], a[4:0], ta, pl};
    endfunction

    // Watchdog: a hung run counts as a failure
    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int          cyc;
        logic        sa, sd;
        int          oe_base;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(RA_CFG, v);     chk("R1 cfg reset", v, 64'h0000_3200);
        rd(RA_CMD, v);     chk("R1 cmd reset", v, 0);
        rd(RA_REGADDR, v); chk("R1 regaddr reset", v, 0);
        rd(RA_DATA, v);    chk("R1 data reset", v, 0);
        chk("R1 mdc/oe reset", {mdc, mdio_oe}, 0);

        wr(RA_CFG, 32'h0000_0200);

        // Table-driven frames, half period 2
        for (int i = 0; i < 7; i++) begin
            logic [1:0]  k;
            logic [7:0]  a8;
            logic [15:0] val, pd;
            logic        e;
            k = VEC[i][42:41]; a8 = VEC[i][40:33]; val = VEC[i][32:17];
            pd = VEC[i][16:1]; e = VEC[i][0];
            phy_is_read = (k == 2'b11); phy_err = e; phy_data = pd;
            if (k != 2'b11) wr(RA_CMD, {24'h0, a8});
            oe_base = oe_low_cnt;
            if (k == 2'b00)      run_frame(RA_REGADDR, {16'h0, val}, cyc, sa, sd);
            else if (k == 2'b01) run_frame(RA_DATA, {16'h0, val}, cyc, sa, sd);
            else                 run_frame(RA_CMD, {16'h0, 8'h80, a8}, cyc, sa, sd);
            chk(k == 2'b00 ? "R2 address frame bits" : (k == 2'b01 ? "R3 write frame bits"
                : "R4 read frame bits"), rx_bits, exp_frame(k, a8, val, pd, e));
            chk("R7 bits per frame", rx_cnt - frame_base, 64);
            chk("R7 frame cycles at half period 2", cyc, 256);
            chk("R5 busy flag select", {sa, sd}, (k == 2'b00) ? 2'b10 : 2'b01);
            chk("R4 released bit times", oe_low_cnt - oe_base, (k == 2'b11) ? 18 : 0);
            if (k == 2'b11) begin
                rd(RA_DATA, v); chk("R4 read data", v, e ? 16'hFFFF : pd);
                rd(RA_CFG, v);  chk("R6 read error flag", v[CFG_RDERR_BIT], e);
                rd(RA_CMD, v);  chk("R10 read bit reads 0", v, a8);
            end else if (k == 2'b01) begin
                rd(RA_DATA, v); chk("R3 data register", v, val);
            end else begin
                rd(RA_REGADDR, v); chk("R2 register number", v, val);
            end
        end
        phy_is_read = 1'b0; phy_err = 1'b0;

        // R10: command write without the read bit starts nothing
        frame_base = rx_cnt;
        wr(RA_CMD, 32'h0000_00C7);
        repeat (20) @(negedge clk);
        chk("R10 no frame", rx_cnt - frame_base, 0);
        rd(RA_CFG, v);  chk("R10 no addr busy", v[CFG_BUSY_BIT], 0);
        rd(RA_CMD, v);  chk("R10 address stored", v, 32'hC7);

        // R9: frame-starting writes during an address frame are dropped
        frame_base = rx_cnt;
        wr(RA_REGADDR, 32'h0000_0101);
        wr(RA_REGADDR, 32'h0000_7777);
        wr(RA_DATA, 32'h0000_9999);
        wr(RA_CMD, 32'h0000_8011);
        rd(RA_CFG, v); chk("R9 addr busy kept", v[CFG_BUSY_BIT], 1);
        rd(RA_DATA, v); chk("R9 data busy not set", v[DATA_BUSY_BIT], 0);
        wait_idle(cyc, sa, sd);
        repeat (40) @(negedge clk);
        chk("R9 single frame only", rx_cnt - frame_base, 64);
        chk("R9 frame carries first value", rx_bits, exp_frame(2'b00, 8'hC7, 16'h0101, 0, 0));
        rd(RA_REGADDR, v); chk("R9 register number kept", v, 32'h0101);
        rd(RA_DATA, v);    chk("R9 data kept", v, 32'h4321);
        rd(RA_CMD, v);     chk("R9 address kept", v, 32'hC7);

        // R7: divider 0 acts as 1, divider 3 gives three-cycle half periods
        wr(RA_CFG, 32'h0000_0000);
        rd(RA_CFG, v); chk("R7 divider field", v, 0);
        run_frame(RA_DATA, 32'h0000_A0A0, cyc, sa, sd);
        chk("R7 frame cycles at divider 0", cyc, 128);
        chk("R3 write frame at divider 0", rx_bits, exp_frame(2'b01, 8'hC7, 16'hA0A0, 0, 0));
        wr(RA_CFG, 32'h0000_0300);
        run_frame(RA_REGADDR, 32'h0000_FFFE, cyc, sa, sd);
        chk("R7 frame cycles at divider 3", cyc, 384);
        chk("R2 address frame at divider 3", rx_bits, exp_frame(2'b00, 8'hC7, 16'hFFFE, 0, 0));
        chk("R7 mdc idle low", {mdc, mdio_oe}, 0);

        // R8: no output change while MDC was high over the whole run
        chk("R8 output held while mdc high", r8_viol, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule